// File: doc/BRIEF.md
# Quasi-Resonant Switching Cycle Scheduler

This block decides the clock cycle in which the next turn-on pulse of a valley-switching power converter begins. It counts clock cycles from its own most recent start pulse. No valley indication may start a cycle before a minimum switching period has run. After that period, the first valley indication starts the next cycle. Two fallback timers cover the case where no usable valley arrives. If valleys did arrive, but only inside the minimum period, the next cycle starts a fixed short delay after that period ends. If no valley arrived at all, a long starter timeout starts it.

The output is a single-cycle start pulse for the on-time controller. Valley detection happens upstream and arrives as a synchronous pulse. The length of the on-time is set elsewhere. All three durations are parameters given in clock cycles. An enable input stops the block. When enable returns, the first start always comes from the starter timeout.

Top module: `qr_cycle_scheduler`

## Requirements
- R1: While reset is asserted, `start_o` is low. When reset is released with `en_i` high, the first start pulse appears exactly `START_CYC` cycles after the first cycle out of reset, and valleys in that interval have no effect.
- R2: Offsets are counted from the start-pulse cycle, which is offset 0. A valley at an offset below `BLANK_CYC` never produces a start pulse.
- R3: If a valley at offset e ≥ `BLANK_CYC` is the first valley at or after `BLANK_CYC`, and no earlier trigger is due, the next start pulse follows one cycle later. The period is then e+1.
- R4: If at least one valley arrived at an offset below `BLANK_CYC` and no later valley arrives first, the next start pulse comes at period `BLANK_CYC`+`EXTRA_CYC`.
- R5: If no valley arrives at any offset, the next start pulse comes at period `START_CYC`.
- R6: A valley seen inside the minimum period affects only the cycle it occurred in. The record of it is cleared at every start pulse.
- R7: While `en_i` is low, `start_o` stays low whatever `valley_i` does. Starting from the cycle after `en_i` falls, no pulse appears.
- R8: After `en_i` rises, the first start pulse appears exactly `START_CYC` cycles after the first enabled cycle, even when valleys arrive in between.
- R9: Each start pulse lasts one cycle. When a valley and the fallback deadline fall in the same cycle, they produce a single pulse at period `BLANK_CYC`+`EXTRA_CYC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Scheduler enable |
| valley_i | input | 1 | Synchronous valley-detect pulse |
| start_o | output | 1 | One-cycle start pulse for the on-time controller |

## Verification
A trigger that is decided from inputs sampled in cycle e shows up on `start_o` in cycle e+1. The bench drives `valley_i` for a given offset just after a falling edge. It samples `start_o` at the next falling edge, and it counts those edges from the cycle in which it saw the previous pulse. The period it measures therefore equals the offset of the deciding cycle plus one. That is the value the bench computes from R3 to R5. Enable and reset changes are applied the same way, so the starter count runs from the first enabled cycle.

// File: rtl/qr_sched_pkg.sv
package qr_sched_pkg;

  typedef enum logic [1:0] {
    SRC_NONE     = 2'd0,
    SRC_VALLEY   = 2'd1,
    SRC_FALLBACK = 2'd2,
    SRC_STARTER  = 2'd3
  } trig_src_e;

  // offset still inside the minimum switching period
  function automatic logic in_blank(input logic [31:0] ofs, input logic [31:0] blank);
    return ofs < blank;
  endfunction

  // last offset before the short fallback start
  function automatic logic fallback_due(input logic [31:0] ofs, input logic [31:0] blank,
                                        input logic [31:0] extra);
    return ofs == (blank + extra - 32'd1);
  endfunction

  // last offset before the starter timeout start
  function automatic logic starter_due(input logic [31:0] ofs, input logic [31:0] start);
    return ofs == (start - 32'd1);
  endfunction

endpackage

// File: rtl/qr_period_timer.sv
module qr_period_timer #(
  parameter int unsigned START_CYC = 1300,
  parameter int unsigned CW        = $clog2(START_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          restart_i,
  output logic [CW-1:0] elapsed_o
);

  localparam logic [CW-1:0] SAT = CW'(START_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || restart_i) begin
      cnt_q <= '0;
    end else if (cnt_q != SAT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign elapsed_o = cnt_q;

endmodule

// File: rtl/qr_blank_tracker.sv
module qr_blank_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic restart_i,
  input  logic valley_i,
  input  logic in_blank_i,
  output logic seen_o
);

  logic seen_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
    end else if (!en_i || restart_i) begin
      seen_q <= 1'b0;
    end else if (valley_i && in_blank_i) begin
      seen_q <= 1'b1;
    end
  end

  assign seen_o = seen_q;

endmodule

// File: rtl/qr_trigger_arbiter.sv
module qr_trigger_arbiter
  import qr_sched_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 85,
  parameter int unsigned EXTRA_CYC = 50,
  parameter int unsigned START_CYC = 1300,
  parameter int unsigned CW        = $clog2(START_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          valley_i,
  input  logic          seen_i,
  input  logic [CW-1:0] elapsed_i,
  output logic          blank_o,
  output logic          fire_o,
  output trig_src_e     src_o,
  output logic          start_o
);

  logic [31:0] ofs;
  logic        armed_q;
  logic        start_q;
  logic        hit_valley, hit_fallback, hit_starter;

  assign ofs          = 32'(elapsed_i);
  assign blank_o      = in_blank(ofs, BLANK_CYC);
  assign hit_valley   = en_i && !armed_q && valley_i && !blank_o;
  assign hit_fallback = en_i && !armed_q && seen_i && fallback_due(ofs, BLANK_CYC, EXTRA_CYC);
  assign hit_starter  = en_i && starter_due(ofs, START_CYC);

  always_comb begin
    if (hit_valley)        src_o = SRC_VALLEY;
    else if (hit_fallback) src_o = SRC_FALLBACK;
    else if (hit_starter)  src_o = SRC_STARTER;
    else                   src_o = SRC_NONE;
  end

  assign fire_o = (src_o != SRC_NONE);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      start_q <= 1'b0;
    end else begin
      start_q <= fire_o;
      if (!en_i)       armed_q <= 1'b1;
      else if (fire_o) armed_q <= 1'b0;
    end
  end

  assign start_o = start_q;

endmodule

// File: rtl/qr_cycle_scheduler.sv
module qr_cycle_scheduler
  import qr_sched_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 85,
  parameter int unsigned EXTRA_CYC = 50,
  parameter int unsigned START_CYC = 1300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic valley_i,
  output logic start_o
);

  localparam int unsigned CW = $clog2(START_CYC + 1);

  logic [CW-1:0] elapsed_w;
  logic          blank_w;
  logic          seen_w;
  logic          fire_w;
  trig_src_e     src_w;

  qr_period_timer #(.START_CYC(START_CYC), .CW(CW)) timer_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .restart_i(fire_w),
    .elapsed_o(elapsed_w)
  );

  qr_blank_tracker tracker_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .restart_i (fire_w),
    .valley_i  (valley_i),
    .in_blank_i(blank_w),
    .seen_o    (seen_w)
  );

  qr_trigger_arbiter #(
    .BLANK_CYC(BLANK_CYC), .EXTRA_CYC(EXTRA_CYC), .START_CYC(START_CYC), .CW(CW)
  ) arb_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .valley_i (valley_i),
    .seen_i   (seen_w),
    .elapsed_i(elapsed_w),
    .blank_o  (blank_w),
    .fire_o   (fire_w),
    .src_o    (src_w),
    .start_o  (start_o)
  );

endmodule

// File: rtl/qr_cycle_scheduler_chk.sv
module qr_cycle_scheduler_chk #(
  parameter int unsigned BLANK_CYC = 85,
  parameter int unsigned EXTRA_CYC = 50,
  parameter int unsigned START_CYC = 1300
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic start_o
);

  logic [31:0] gap_q;
  logic        had_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !en_i) begin
      gap_q <= '0;
      had_q <= 1'b0;
    end else if (start_o) begin
      gap_q <= 32'd1;
      had_q <= 1'b1;
    end else if (gap_q != 32'hFFFF_FFFF) begin
      gap_q <= gap_q + 32'd1;
    end
  end

  AST_MIN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start_o && had_q) |-> (gap_q > BLANK_CYC)); // R2

  AST_MAX_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (gap_q <= START_CYC)); // R5

  AST_FIRST_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start_o && !had_q) |-> (gap_q == START_CYC)); // R8

  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R9

  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !start_o); // R7

endmodule

bind qr_cycle_scheduler qr_cycle_scheduler_chk #(
  .BLANK_CYC(BLANK_CYC), .EXTRA_CYC(EXTRA_CYC), .START_CYC(START_CYC)
) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .start_o(start_o)
);

// File: tb/qr_cycle_scheduler_tb_top.sv
`timescale 1ns/1ps
module qr_cycle_scheduler_tb_top;

  localparam int BLANK = 8;
  localparam int EXTRA = 4;
  localparam int START = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic valley = 1'b0;
  logic start;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit ended   = 1'b0;

  always #5 clk = ~clk;

  qr_cycle_scheduler #(.BLANK_CYC(BLANK), .EXTRA_CYC(EXTRA), .START_CYC(START)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .valley_i(valley), .start_o(start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // period predicted from the valley offsets in pat
  function automatic int model_period(input logic [63:0] pat);
    int  res = START;
    bit  seen = 1'b0;
    for (int k = 0; k < START; k++) begin
      if (pat[k]) begin
        if (k < BLANK) seen = 1'b1;
        else if (k + 1 < res) res = k + 1;
      end
    end
    if (seen && (BLANK + EXTRA) < res) res = BLANK + EXTRA;
    return res;
  endfunction

  // Called at a falling edge of offset 0; returns at the falling edge of the next pulse
  task automatic run_period(input logic [63:0] pat, input int exp, input string req);
    int k = 0;
    bit done = 1'b0;
    while (!done) begin
      valley = (k < 64) ? pat[k] : 1'b0;
      @(negedge clk);
      k++;
      if (start || k > 4 * START) done = 1'b1;
    end
    valley = 1'b0;
    check(start && k == exp, req, k, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    logic [63:0] p;
    en = 1'b1;
    // R1 reset state
    repeat (4) begin
      @(negedge clk);
      check(start == 1'b0, "R1", start, 0);
    end
    rst_n = 1'b1;
    p = '0; p[BLANK + 2] = 1'b1;
    run_period(p, START, "R1");

    // single valley at every offset
    for (int v = 0; v < START + 2; v++) begin
      p = '0; p[v] = 1'b1;
      if (v < BLANK)      run_period(p, model_period(p), "R2 R4");
      else if (v < START) run_period(p, model_period(p), "R3");
      else                run_period(p, model_period(p), "R5");
    end

    // no valley
    run_period('0, START, "R5");
    run_period('0, START, "R5");

    // pairs: one valley inside blank, one after
    for (int a = 0; a < BLANK; a++) begin
      for (int b = BLANK; b < START; b++) begin
        p = '0; p[a] = 1'b1; p[b] = 1'b1;
        if (b == BLANK + EXTRA - 1) run_period(p, model_period(p), "R9");
        else                        run_period(p, model_period(p), "R3 R4");
      end
    end

    // R6 flag cleared: fallback cycle then a valley-free cycle
    p = '0; p[1] = 1'b1;
    run_period(p, BLANK + EXTRA, "R4");
    run_period('0, START, "R6");
    p = '0; p[3] = 1'b1;
    run_period(p, BLANK + EXTRA, "R4");
    p = '0; p[BLANK + EXTRA + 3] = 1'b1;
    run_period(p, BLANK + EXTRA + 4, "R6");

    // R7 disable in mid period
    repeat (3) @(negedge clk);
    en = 1'b0;
    for (int i = 0; i < 3 * START; i++) begin
      valley = i[0];
      @(negedge clk);
      check(start == 1'b0, "R7", start, 0);
    end
    valley = 1'b0;
    en = 1'b1;
    p = '0; p[BLANK] = 1'b1; p[2] = 1'b1; p[BLANK + 5] = 1'b1;
    run_period(p, START, "R8");
    p = '0; p[BLANK] = 1'b1;
    run_period(p, BLANK + 1, "R3");

    finish_run();
  end

endmodule